// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block turns single-word read and write requests into the command stream of a four-bank synchronous DRAM. A request carries a bank, a row, a column, a direction and, for writes, one data word. The block opens the row with an activate command, waits the row-to-column gap, and then issues the column command with the auto-precharge bit set. The DRAM closes the row by itself at the end of the one-beat burst. Read data returns on `rd_data` with a one-cycle `rd_valid` strobe, captured after the programmed CAS latency.

After reset the block issues one mode-register load. This load sets a burst length of one, sequential ordering, and a CAS latency of 2 or 3, taken from `cas_lat3`. A free-running interval timer requests an auto-refresh once per `REF_INTERVAL` clocks. The default of 390 clocks at 50 MHz spreads 8192 refreshes over 64 ms. A pending refresh wins over a waiting request: all banks are precharged first, then the refresh command is sent.

The controller has eight states. BOOT lasts one NOP cycle and goes to MODE_LOAD. MODE_LOAD goes to GAP_WAIT, which leads to IDLE. IDLE goes to PRE_ALL when a refresh is pending, or to ACTIVATE when a request is accepted. PRE_ALL leads through GAP_WAIT to REFRESH. REFRESH leads through GAP_WAIT back to IDLE. ACTIVATE leads through GAP_WAIT to ACCESS. ACCESS leads through GAP_WAIT back to IDLE. GAP_WAIT drives NOPs until the shared gap timer expires, then enters the target that was stored on the way in.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Command pins {cs_n,ras_n,cas_n,we_n} use these encodings: ACTIVE=0011, READ=0101, WRITE=0100, PRECHARGE=0010, REFRESH=0001, LOAD MODE=0000, NOP=0111. Every access starts with ACTIVE, carrying the request bank on `dram_ba` and the row on `dram_addr`, and the cycle after ACTIVE is a NOP.
- R2: The READ or WRITE command follows exactly T_RCD cycles after ACTIVE. It carries the same bank and the column on `dram_addr[COL_W-1:0]`.
- R3: Every READ and WRITE drives `dram_addr[10]` high (auto precharge). The refresh precharge also drives `dram_addr[10]` high (all banks).
- R4: `dram_dq_oe` is high only in the WRITE cycle, and `dram_dq_out` then carries the request's write word. It stays low for reads.
- R5: Read data present on `dram_dq_in` at the CL-th rising edge after the READ edge is returned on `rd_data`, with `rd_valid` high for one cycle: the (CL+1)-th cycle after the READ cycle.
- R6: After reset release there is one BOOT NOP cycle. The next command is LOAD MODE with `dram_addr[6:4]` = CL (2 or 3, from `cas_lat3`) and `dram_addr[2:0]` = 000. The next command comes at least T_MRD cycles later.
- R7: Each REFRESH comes exactly T_RP cycles after an all-bank PRECHARGE. The next command comes at least T_RFC cycles after the REFRESH.
- R8: When a refresh is pending, a waiting request is held off. Its ACTIVE comes only after the REFRESH, and at least T_RFC cycles after it.
- R9: `req_ready` is low while any command sequence is in progress. An accepted access with no refresh behind it keeps `req_ready` low for exactly T_RCD+CL+T_RP cycles.
- R10: While reset is asserted the pins show NOP, and `req_ready` and `rd_valid` are low.
- R11: When the block is idle, consecutive REFRESH commands are REF_INTERVAL cycles apart. They drift by no more than the length of one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cas_lat3 | input | 1 | CAS latency select (1: three clocks, 0: two), sampled in MODE_LOAD |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on a cycle with valid and ready both high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DQ_W | Write word |
| rd_valid | output | 1 | Read word valid, one cycle |
| rd_data | output | DQ_W | Read word |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_ba | output | BANK_W | Bank select |
| dram_addr | output | ROW_W | Multiplexed row/column/mode address |
| dram_dq_out | output | DQ_W | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Data output enable |
| dram_dq_in | input | DQ_W | Data from the DRAM |

## Verification
A table of accesses is run against a small DRAM model that honours the mode register it receives. The table mixes reads and writes, all four banks, rows 0 and 8191, and columns 0, 510 and 511. These patterns separate bank and row from column multiplexing, and expose a column field cut short or an auto-precharge bit left low.

The model drives the read word only on the edge that the programmed latency selects, so a capture one edge early or late returns a different word. Reads are therefore repeated after a reset with latency 3. A long idle stretch shows refresh spacing and the precharge-to-refresh order. A request raised while a refresh is pending tells priority apart from first-come service.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE = 4'b0000,
        CMD_REF  = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_ACT  = 4'b0011,
        CMD_WR   = 4'b0100,
        CMD_RD   = 4'b0101,
        CMD_NOP  = 4'b0111
    } dram_cmd_e;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_MODE,
        ST_IDLE,
        ST_ACT,
        ST_ACCESS,
        ST_PRE,
        ST_REF,
        ST_WAIT
    } seq_state_e;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         expire
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= value;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    // last NOP cycle of the gap
    assign expire = (cnt_q == W'(1));

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int INTERVAL = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic pending
);

    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else begin
            cnt_q <= wrap ? '0 : cnt_q + CW'(1);
            if (wrap) begin
                pending <= 1'b1;
            end else if (ack) begin
                pending <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sdram_read_pipe.sv
module sdram_read_pipe #(
    parameter int DQ_W   = 16,
    parameter int MAX_CL = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          issue,
    input  logic [$clog2(MAX_CL+1)-1:0]   cl,
    input  logic [DQ_W-1:0]               dq_in,
    output logic                          rd_valid,
    output logic [DQ_W-1:0]               rd_data
);

    localparam int CL_W = $clog2(MAX_CL + 1);

    logic [MAX_CL-1:0] pend_q;
    logic              take;

    always_ff @(posedge clk) begin
        if (rst) pend_q[0] <= 1'b0;
        else     pend_q[0] <= issue;
    end

    for (genvar i = 1; i < MAX_CL; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pend_q[i] <= 1'b0;
            else     pend_q[i] <= pend_q[i-1];
        end
    end

    always_comb begin
        take = 1'b0;
        for (int i = 0; i < MAX_CL; i++) begin
            if (CL_W'(i + 1) == cl) take = pend_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= take;
            if (take) rd_data <= dq_in;
        end
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W       = 2,
    parameter int ROW_W        = 13,
    parameter int COL_W        = 9,
    parameter int DQ_W         = 16,
    parameter int T_MRD        = 2,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 2,
    parameter int T_RFC        = 4,
    parameter int REF_INTERVAL = 390
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cas_lat3,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic              dram_cs_n,
    output logic              dram_ras_n,
    output logic              dram_cas_n,
    output logic              dram_we_n,
    output logic [BANK_W-1:0] dram_ba,
    output logic [ROW_W-1:0]  dram_addr,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);

    localparam int ADDR_W  = ROW_W;
    localparam int AP_BIT  = 10;
    localparam int MAX_CL  = 3;
    localparam int CL_W    = $clog2(MAX_CL + 1);
    localparam int GAP_SUM = T_MRD + T_RCD + T_RP + T_RFC + MAX_CL;
    localparam int GAP_W   = $clog2(GAP_SUM + 1);

    seq_state_e        state_q, state_d, tgt_q, tgt_d;
    dram_cmd_e         cmd;
    logic [CL_W-1:0]   cl_q;
    logic              wr_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [DQ_W-1:0]   wdata_q;
    logic              take_req, gap_load, gap_done, ref_pend, ref_ack, rd_issue;
    logic [GAP_W-1:0]  gap_val;

    sdram_gap_timer #(.W(GAP_W)) u_gap (
        .clk(clk), .rst(rst), .load(gap_load), .value(gap_val), .expire(gap_done)
    );

    sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
        .clk(clk), .rst(rst), .ack(ref_ack), .pending(ref_pend)
    );

    sdram_read_pipe #(.DQ_W(DQ_W), .MAX_CL(MAX_CL)) u_rpipe (
        .clk(clk), .rst(rst), .issue(rd_issue), .cl(cl_q),
        .dq_in(dram_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    // next state
    always_comb begin
        state_d  = state_q;
        tgt_d    = tgt_q;
        gap_load = 1'b0;
        gap_val  = '0;
        ref_ack  = 1'b0;
        take_req = 1'b0;
        unique case (state_q)
            ST_BOOT: state_d = ST_MODE;
            ST_MODE: begin
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_MRD - 1);
                tgt_d    = ST_IDLE;
                state_d  = ST_WAIT;
            end
            ST_IDLE: begin
                if (ref_pend) begin
                    state_d = ST_PRE;
                end else if (req_valid) begin
                    take_req = 1'b1;
                    state_d  = ST_ACT;
                end
            end
            ST_ACT: begin
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RCD - 1);
                tgt_d    = ST_ACCESS;
                state_d  = ST_WAIT;
            end
            ST_ACCESS: begin
                gap_load = 1'b1;
                gap_val  = GAP_W'(cl_q) + GAP_W'(T_RP - 1);
                tgt_d    = ST_IDLE;
                state_d  = ST_WAIT;
            end
            ST_PRE: begin
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RP - 1);
                tgt_d    = ST_REF;
                state_d  = ST_WAIT;
            end
            ST_REF: begin
                ref_ack  = 1'b1;
                gap_load = 1'b1;
                gap_val  = GAP_W'(T_RFC - 1);
                tgt_d    = ST_IDLE;
                state_d  = ST_WAIT;
            end
            ST_WAIT: begin
                if (gap_done) state_d = tgt_q;
            end
            default: state_d = ST_BOOT;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            tgt_q   <= ST_IDLE;
            cl_q    <= CL_W'(2);
            wr_q    <= 1'b0;
            bank_q  <= '0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
            if (state_q == ST_MODE) cl_q <= cas_lat3 ? CL_W'(3) : CL_W'(2);
            if (take_req) begin
                wr_q    <= req_write;
                bank_q  <= req_bank;
                row_q   <= req_row;
                col_q   <= req_col;
                wdata_q <= req_wdata;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        cmd         = CMD_NOP;
        dram_ba     = '0;
        dram_addr   = '0;
        dram_dq_oe  = 1'b0;
        dram_dq_out = '0;
        req_ready   = 1'b0;
        rd_issue    = 1'b0;
        unique case (state_q)
            ST_MODE: begin
                cmd            = CMD_MODE;
                dram_addr[6:4] = cas_lat3 ? 3'd3 : 3'd2;
            end
            ST_IDLE: req_ready = !ref_pend;
            ST_ACT: begin
                cmd       = CMD_ACT;
                dram_ba   = bank_q;
                dram_addr = row_q;
            end
            ST_ACCESS: begin
                cmd                    = wr_q ? CMD_WR : CMD_RD;
                dram_ba                = bank_q;
                dram_addr[COL_W-1:0]   = col_q;
                dram_addr[AP_BIT]      = 1'b1;
                if (wr_q) begin
                    dram_dq_oe  = 1'b1;
                    dram_dq_out = wdata_q;
                end else begin
                    rd_issue = 1'b1;
                end
            end
            ST_PRE: begin
                cmd               = CMD_PRE;
                dram_addr[AP_BIT] = 1'b1;
            end
            ST_REF: cmd = CMD_REF;
            default: ;
        endcase
    end

    assign {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} = cmd;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int T_RCD = 2,
    parameter int T_RP  = 2
) (
    input logic       clk,
    input logic       rst,
    input logic [3:0] cmd_bits,
    input logic       ap_bit,
    input logic       dq_oe,
    input logic       req_ready,
    input logic       rd_valid,
    input logic       ref_pend
);

    logic is_act, is_rw, is_wr, is_ref, is_pre, is_nop;
    logic [7:0] since_act, since_pre;

    assign is_act = (cmd_bits == CMD_ACT);
    assign is_wr  = (cmd_bits == CMD_WR);
    assign is_rw  = is_wr || (cmd_bits == CMD_RD);
    assign is_ref = (cmd_bits == CMD_REF);
    assign is_pre = (cmd_bits == CMD_PRE);
    assign is_nop = (cmd_bits == CMD_NOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            since_act <= '0;
            since_pre <= '0;
        end else begin
            since_act <= is_act ? 8'd1 : ((since_act == 8'hFF) ? since_act : since_act + 8'd1);
            since_pre <= is_pre ? 8'd1 : ((since_pre == 8'hFF) ? since_pre : since_pre + 8'd1);
        end
    end

    assert_act_then_nop_R1: assert property (@(posedge clk) disable iff (rst)
        is_act |=> (cmd_bits == CMD_NOP));

    assert_rw_gap_R2: assert property (@(posedge clk) disable iff (rst)
        is_rw |-> (since_act == 8'(T_RCD)));

    assert_autopre_R3: assert property (@(posedge clk) disable iff (rst)
        (is_rw || is_pre) |-> ap_bit);

    assert_oe_write_R4: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> is_wr);

    assert_single_beat_R5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    assert_ref_after_pre_R7: assert property (@(posedge clk) disable iff (rst)
        is_ref |-> (since_pre == 8'(T_RP)));

    assert_refresh_first_R8: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> !req_ready);

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        !is_nop |-> !req_ready);

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
    .clk(clk),
    .rst(rst),
    .cmd_bits({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}),
    .ap_bit(dram_addr[10]),
    .dq_oe(dram_dq_oe),
    .req_ready(req_ready),
    .rd_valid(rd_valid),
    .ref_pend(ref_pend)
);

// File: tb/sdram_cmd_seq_bench.sv
module sdram_cmd_seq_bench;

    localparam int T_MRD = 2, T_RCD = 2, T_RP = 2, T_RFC = 4, RI = 390;
    localparam logic [3:0] C_MODE = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                           C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101, C_NOP = 4'b0111;

    // {write, bank, row, col, wdata}
    localparam logic [40:0] VEC [8] = '{
        {1'b1, 2'd0, 13'd0,    9'd0,   16'h1234},
        {1'b0, 2'd0, 13'd0,    9'd0,   16'h0000},
        {1'b1, 2'd3, 13'd8191, 9'd511, 16'hBEEF},
        {1'b0, 2'd3, 13'd8191, 9'd510, 16'h0000},
        {1'b0, 2'd1, 13'd1234, 9'd5,   16'h0000},
        {1'b1, 2'd2, 13'd4096, 9'd256, 16'hA5A5},
        {1'b0, 2'd2, 13'd42,   9'd511, 16'h0000},
        {1'b0, 2'd1, 13'd8191, 9'd0,   16'h0000}
    };

    logic clk = 1'b0, rst = 1'b1, cas_lat3 = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_ready;
    logic [1:0] req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0] req_col = '0;
    logic [15:0] req_wdata = '0, rd_data, dram_dq_out, dram_dq_in = '0;
    logic rd_valid, dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [1:0] dram_ba;
    logic [12:0] dram_addr;
    logic [3:0] pins;

    always #10 clk = ~clk;

    sdram_cmd_seq u_sdram_cmd_seq (
        .clk(clk), .rst(rst), .cas_lat3(cas_lat3),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_cs_n(dram_cs_n), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_ba(dram_ba), .dram_addr(dram_addr),
        .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    assign pins = {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n};

    int cyc = 0, lg_n = 0, rv_n = 0, n_chk = 0, n_fail = 0;
    int lg_cyc [512];
    logic [3:0] lg_cmd [512];
    logic [1:0] lg_ba [512];
    logic [12:0] lg_addr [512];
    logic [15:0] lg_dq [512];
    logic lg_oe [512];
    int rv_cyc [64];
    logic [15:0] rv_data [64];

    // DRAM model and command log, sampled mid-cycle
    initial begin
        int rd_cnt, m_cl;
        logic [15:0] rd_val;
        logic [12:0] act_row;
        rd_cnt = 0; m_cl = 2; rd_val = '0; act_row = '0;
        forever begin
            @(negedge clk);
            cyc++;
            dram_dq_in = (rd_cnt == 1) ? rd_val : (rd_val ^ 16'h5A5A);
            if (rd_cnt != 0) rd_cnt--;
            if (!rst && pins != C_NOP && lg_n < 512) begin
                lg_cyc[lg_n] = cyc; lg_cmd[lg_n] = pins; lg_ba[lg_n] = dram_ba;
                lg_addr[lg_n] = dram_addr; lg_dq[lg_n] = dram_dq_out; lg_oe[lg_n] = dram_dq_oe;
                lg_n++;
                if (pins == C_MODE) m_cl = int'(dram_addr[6:4]);
                if (pins == C_ACT) act_row = dram_addr;
                if (pins == C_RD) begin
                    rd_cnt = m_cl;
                    rd_val = {act_row[6:0], dram_addr[8:0]};
                end
            end
            if (!rst && rd_valid && rv_n < 64) begin
                rv_cyc[rv_n] = cyc; rv_data[rv_n] = rd_data; rv_n++;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic cl3, output int ps);
        rst = 1'b1; cas_lat3 = cl3;
        repeat (3) @(negedge clk);
        chk(pins == C_NOP, "R10 pins NOP in reset", 32'(pins), 32'(C_NOP));
        chk(!req_ready, "R10 ready low in reset", 32'(req_ready), 0);
        chk(!rd_valid, "R10 rd_valid low in reset", 32'(rd_valid), 0);
        ps = lg_n;
        rst = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        chk(lg_n > ps && lg_cmd[ps] == C_MODE, "R6 first command is LOAD MODE", 32'(lg_cmd[ps]), 32'(C_MODE));
        chk(lg_addr[ps][6:4] == (cl3 ? 3'd3 : 3'd2), "R6 mode latency field", 32'(lg_addr[ps][6:4]), cl3 ? 3 : 2);
        chk(lg_addr[ps][2:0] == 3'd0, "R6 mode burst length field", 32'(lg_addr[ps][2:0]), 0);
    endtask

    task automatic run_vec(input logic [40:0] v, input int cl);
        int start, busy, ia, irw, found;
        logic [15:0] exp_rd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        start = lg_n;
        req_valid = 1'b1; req_write = v[40]; req_bank = v[39:38];
        req_row = v[37:25]; req_col = v[24:16]; req_wdata = v[15:0];
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready) begin busy++; @(negedge clk); end
        @(negedge clk);
        ia = -1;
        for (int i = start; i < lg_n; i++) if (ia < 0 && lg_cmd[i] == C_ACT) ia = i;
        chk(ia >= 0, "R1 ACTIVE issued", 32'(ia), 0);
        if (ia < 0) return;
        chk(lg_ba[ia] == v[39:38], "R1 ACTIVE bank", 32'(lg_ba[ia]), 32'(v[39:38]));
        chk(lg_addr[ia] == v[37:25], "R1 ACTIVE row", 32'(lg_addr[ia]), 32'(v[37:25]));
        irw = ia + 1;
        chk(lg_cmd[irw] == (v[40] ? C_WR : C_RD), "R2 column command", 32'(lg_cmd[irw]), 32'(v[40] ? C_WR : C_RD));
        chk(lg_cyc[irw] - lg_cyc[ia] == T_RCD, "R2 ACTIVE to column gap", 32'(lg_cyc[irw] - lg_cyc[ia]), T_RCD);
        chk(lg_addr[irw][8:0] == v[24:16] && lg_ba[irw] == v[39:38], "R2 column and bank",
            32'({lg_ba[irw], lg_addr[irw][8:0]}), 32'({v[39:38], v[24:16]}));
        chk(lg_addr[irw][10], "R3 auto precharge bit", 32'(lg_addr[irw][10]), 1);
        if (v[40]) begin
            chk(lg_oe[irw] && lg_dq[irw] == v[15:0], "R4 write data on pins", 32'({lg_oe[irw], lg_dq[irw]}), 32'({1'b1, v[15:0]}));
        end else begin
            chk(!lg_oe[irw], "R4 no drive on read", 32'(lg_oe[irw]), 0);
            exp_rd = {v[31:25], v[24:16]};
            found = 0;
            for (int k = 0; k < rv_n; k++) begin
                if (rv_cyc[k] == lg_cyc[irw] + cl + 1) begin
                    found = 1;
                    chk(rv_data[k] == exp_rd, "R5 read word", 32'(rv_data[k]), 32'(exp_rd));
                end
            end
            chk(found == 1, "R5 rd_valid timing", 32'(found), 1);
        end
        if (lg_n == irw + 1)
            chk(busy == T_RCD + cl + T_RP, "R9 busy length", 32'(busy), 32'(T_RCD + cl + T_RP));
    endtask

    task automatic scan_refresh(input int ps);
        int prev;
        prev = -1;
        for (int i = ps; i < lg_n; i++) begin
            if (lg_cmd[i] == C_REF) begin
                chk(i > ps && lg_cmd[i-1] == C_PRE && lg_addr[i-1][10], "R7 all-bank precharge before refresh",
                    32'(lg_cmd[i-1]), 32'(C_PRE));
                chk(lg_cyc[i] - lg_cyc[i-1] == T_RP, "R7 precharge to refresh gap", 32'(lg_cyc[i] - lg_cyc[i-1]), T_RP);
                if (i + 1 < lg_n)
                    chk(lg_cyc[i+1] - lg_cyc[i] >= T_RFC, "R7 refresh recovery", 32'(lg_cyc[i+1] - lg_cyc[i]), T_RFC);
                if (prev >= 0)
                    chk(lg_cyc[i] - prev >= RI - 12 && lg_cyc[i] - prev <= RI + 12, "R11 refresh spacing",
                        32'(lg_cyc[i] - prev), RI);
                prev = lg_cyc[i];
            end
        end
    endtask

    initial begin
        int ps, start, ir, ia;
        do_reset(1'b0, ps);
        for (int n = 0; n < 8; n++) run_vec(VEC[n], 2);
        repeat (3 * RI) @(negedge clk);
        // R8: raise a request while a refresh is pending
        while (req_ready) @(negedge clk);
        start = lg_n;
        req_valid = 1'b1; req_write = 1'b0; req_bank = 2'd2; req_row = 13'd77; req_col = 9'd3;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (12) @(negedge clk);
        ir = -1; ia = -1;
        for (int i = start; i < lg_n; i++) begin
            if (ir < 0 && lg_cmd[i] == C_REF) ir = i;
            if (ia < 0 && lg_cmd[i] == C_ACT) ia = i;
        end
        chk(ir >= 0 && ia > ir, "R8 refresh before held request", 32'(ia), 32'(ir + 1));
        if (ir >= 0 && ia > ir)
            chk(lg_cyc[ia] - lg_cyc[ir] >= T_RFC, "R8 ACTIVE after refresh recovery", 32'(lg_cyc[ia] - lg_cyc[ir]), T_RFC);
        scan_refresh(ps);
        do_reset(1'b1, ps);
        for (int n = 0; n < 5; n++) run_vec(VEC[n], 3);
        run_vec(VEC[6], 3);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule